// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo serial stream into parallel samples. The three wires are a word clock that selects the channel, a bit clock and serial data. All three are sampled in the system clock domain. Each stereo frame produces a left and a right sample. Both are 24 bits wide and aligned to the MSB. A single-cycle valid strobe marks each new pair.

A 3-bit format code selects the framing:

- I2S, with 64 or 32 bit clocks per frame.
- Left-justified, 24-bit.
- Right-justified, at 24, 20, 18 or 16 bits.

One spare code behaves as a copy of the short I2S mode.

A power-down input silences the outputs. While power-down is high, the format code is loaded. While power-down is low, the format code is held. The loaded code stays in place through later power-down periods until a new value is loaded. The parent releases power-down once the format is settled, and samples start to appear.

Top module: `aud_serial_rx`

## Requirements
- R1: Format code 000 is I2S with 64 bit clocks per frame and 24-bit data. A low word clock marks left. The MSB is on the second rising bit clock after a word clock change. Bits past the 24th are ignored.
- R2: Format code 001 is I2S with 32 bit clocks per frame and 16-bit data. The LSB is on the first rising bit clock after the next word clock change. Output bits 7:0 are zero.
- R3: Format code 010 is left-justified with 24-bit data. A high word clock marks left. The MSB is on the first rising bit clock after a word clock change. Bits past the 24th are ignored.
- R4: Format codes 011, 100, 101 and 110 are right-justified at 24, 20, 16 and 18 bits. A high word clock marks left. The LSB is the last bit before the word clock change. Only the final N bits of each half-frame are kept, and output bits below 24-N are zero.
- R5: Format code 111 decodes the same as code 001.
- R6: After the right half of a frame is captured, `valid_o` pulses high for exactly one cycle. In that cycle `left_o` and `right_o` show that frame's pair. Each frame gives one pulse.
- R7: While `pdn_i` is high, `valid_o` is low and both sample outputs are zero from the next cycle onward. Serial traffic during that time produces no sample.
- R8: The format is loaded from `fmt_i` only while `pdn_i` is high. Changes on `fmt_i` while `pdn_i` is low have no effect.
- R9: After reset, `left_o`, `right_o` and `valid_o` are all zero.
- R10: Serial data is taken at the rising bit clock edge. Bit clock, word clock and data each pass through two synchronizing flops in the system clock domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pdn_i | input | 1 | Power-down; high silences outputs and loads the format |
| fmt_i | input | 3 | Framing format code |
| bclk_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Word clock (channel select) |
| sdata_i | input | 1 | Serial data |
| left_o | output | 24 | Left sample, MSB-aligned |
| right_o | output | 24 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
Every format code is driven with streams that put all-ones filler in the bit slots outside the data word.

- In right-justified modes, an error in the bit count shows up as ones leaking into the result.
- In the I2S and left-justified modes, the same filler separates a one-bit delay error from a word-length error.
- Distinct left and right values expose any channel swap caused by word clock polarity.

A format change applied while running must leave the decoding unchanged. Traffic sent while powered down must produce no strobes.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int SHIFT_W  = 32;
  localparam int CNT_W    = $clog2(SHIFT_W + 1);
  localparam int WID_W    = 5;

  typedef enum logic [1:0] {MODE_I2S, MODE_LJ, MODE_RJ} frame_mode_e;

  function automatic frame_mode_e fmt_mode(input logic [2:0] f);
    case (f)
      3'b000, 3'b001, 3'b111: fmt_mode = MODE_I2S;
      3'b010:                 fmt_mode = MODE_LJ;
      default:                fmt_mode = MODE_RJ;
    endcase
  endfunction

  function automatic logic [WID_W-1:0] fmt_width(input logic [2:0] f);
    case (f)
      3'b001, 3'b101, 3'b111: fmt_width = WID_W'(16);
      3'b100:                 fmt_width = WID_W'(20);
      3'b110:                 fmt_width = WID_W'(18);
      default:                fmt_width = WID_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] ff1_q, ff2_q, ff3_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ff1_q[i] <= 1'b0;
          ff2_q[i] <= 1'b0;
          ff3_q[i] <= 1'b0;
        end else begin
          ff1_q[i] <= in_i[i];
          ff2_q[i] <= ff1_q[i];
          ff3_q[i] <= ff2_q[i];
        end
      end
      assign rise_o[i] = ff2_q[i] & ~ff3_q[i];
    end
  endgenerate

  assign out_o = ff2_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o[0] |=> !rise_o[0]); // R10
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import aud_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  frame_mode_e         mode_i,
  input  logic                rise_i,
  input  logic                lr_i,
  input  logic                sd_i,
  output logic                cap_o,
  output logic                cap_left_o,
  output logic [SHIFT_W-1:0]  cap_sh_o,
  output logic [CNT_W-1:0]    cap_cnt_o
);
  logic               seen_q, armed_q, lr_last_q;
  logic [SHIFT_W-1:0] sh_q, sh_nxt;
  logic [CNT_W-1:0]   cnt_q, cnt_inc;
  logic               edge_w, left_w;

  assign sh_nxt  = {sh_q[SHIFT_W-2:0], sd_i};
  assign cnt_inc = (cnt_q == CNT_W'(SHIFT_W)) ? cnt_q : cnt_q + 1'b1;
  assign edge_w  = seen_q && (lr_i != lr_last_q);
  // I2S: low word clock is left; other framings: high is left
  assign left_w  = (mode_i == MODE_I2S) ? ~lr_last_q : lr_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0; armed_q <= 1'b0; lr_last_q <= 1'b0;
      sh_q <= '0; cnt_q <= '0;
      cap_o <= 1'b0; cap_left_o <= 1'b0; cap_sh_o <= '0; cap_cnt_o <= '0;
    end else if (clr_i) begin
      seen_q <= 1'b0; armed_q <= 1'b0; cnt_q <= '0; cap_o <= 1'b0;
    end else begin
      cap_o <= 1'b0;
      if (rise_i) begin
        seen_q    <= 1'b1;
        lr_last_q <= lr_i;
        sh_q      <= sh_nxt;
        if (edge_w) begin
          armed_q    <= 1'b1;
          cap_o      <= armed_q;
          cap_left_o <= left_w;
          if (mode_i == MODE_I2S) begin
            // one-bit delay: this bit closes the previous word
            cap_sh_o  <= sh_nxt;
            cap_cnt_o <= cnt_inc;
            cnt_q     <= '0;
          end else begin
            cap_sh_o  <= sh_q;
            cap_cnt_o <= cnt_q;
            cnt_q     <= CNT_W'(1);
          end
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  AST_CAP_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> $past(rise_i)); // R10
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> cap_cnt_o <= CNT_W'(SHIFT_W)); // R4
endmodule

// File: rtl/word_align.sv
module word_align
  import aud_rx_pkg::*;
(
  input  frame_mode_e          mode_i,
  input  logic [WID_W-1:0]     width_i,
  input  logic [SHIFT_W-1:0]   sh_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output logic [SAMPLE_W-1:0]  word_o
);
  logic [CNT_W-1:0]   nb, wid;
  logic [SHIFT_W-1:0] v, m, al;

  assign wid = CNT_W'(width_i);

  always_comb begin
    if (mode_i == MODE_RJ) begin
      nb = wid;
      v  = sh_i;
    end else begin
      nb = (cnt_i < wid) ? cnt_i : wid;
      v  = sh_i >> (cnt_i - nb);
    end
    m  = (SHIFT_W'(1) << nb) - SHIFT_W'(1);
    al = (v & m) << (CNT_W'(SAMPLE_W) - nb);
  end

  assign word_o = al[SAMPLE_W-1:0];

  always_comb begin
    if (mode_i == MODE_RJ)
      AST_RJ_WIDTH: assert (nb <= CNT_W'(SAMPLE_W)); // R4
  end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pdn_i,
  input  logic [2:0]          fmt_i,
  input  logic                bclk_i,
  input  logic                lrck_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [2:0]          fmt_q;
  logic [2:0]          s_val, s_rise;
  logic                cap, cap_left;
  logic [SHIFT_W-1:0]  cap_sh;
  logic [CNT_W-1:0]    cap_cnt;
  logic [SAMPLE_W-1:0] word, l_hold_q;
  logic                have_left_q;
  frame_mode_e         mode;
  logic [WID_W-1:0]    width;

  assign mode  = fmt_mode(fmt_q);
  assign width = fmt_width(fmt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fmt_q <= 3'b000;
    else if (pdn_i) fmt_q <= fmt_i;
  end

  bit_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({sdata_i, lrck_i, bclk_i}),
    .out_o (s_val),
    .rise_o(s_rise)
  );

  rx_framer u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (pdn_i),
    .mode_i    (mode),
    .rise_i    (s_rise[0]),
    .lr_i      (s_val[1]),
    .sd_i      (s_val[2]),
    .cap_o     (cap),
    .cap_left_o(cap_left),
    .cap_sh_o  (cap_sh),
    .cap_cnt_o (cap_cnt)
  );

  word_align u_align (
    .mode_i (mode),
    .width_i(width),
    .sh_i   (cap_sh),
    .cnt_i  (cap_cnt),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o <= '0; right_o <= '0; valid_o <= 1'b0;
      l_hold_q <= '0; have_left_q <= 1'b0;
    end else if (pdn_i) begin
      left_o <= '0; right_o <= '0; valid_o <= 1'b0;
      have_left_q <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap) begin
        if (cap_left) begin
          l_hold_q    <= word;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          left_o      <= l_hold_q;
          right_o     <= word;
          valid_o     <= 1'b1;
          have_left_q <= 1'b0;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6
  AST_PDN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_i |=> (!valid_o && left_o == '0 && right_o == '0)); // R7
  AST_FMT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_i |=> $stable(fmt_q)); // R8
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((right_o & ~({SAMPLE_W{1'b1}} << (SAMPLE_W - int'(width)))) == '0)); // R4
endmodule

// File: tb/sim_aud_serial_rx.sv
module sim_aud_serial_rx;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pdn = 1'b1;
  logic [2:0]  fmt = 3'b000;
  logic        bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int n_chk = 0, n_fail = 0, n_valid = 0;
  logic [23:0] got_l [64];
  logic [23:0] got_r [64];
  int t_mode, t_w, t_hb;
  logic carry;

  always #(CLK_P/2) clk = ~clk;

  aud_serial_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pdn_i(pdn), .fmt_i(fmt),
    .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdata),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (valid_o) begin
      got_l[n_valid % 64] = left_o;
      got_r[n_valid % 64] = right_o;
      n_valid++;
    end
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic slot(input logic lr, input logic d);
    bclk = 1'b0; lrck = lr; sdata = d;
    wait_clk(HALF);
    bclk = 1'b1;
    wait_clk(HALF);
  endtask

  function automatic logic dbit(input logic [23:0] w, input int k);
    return (k < t_w) ? w[23-k] : 1'b1;
  endfunction

  task automatic send_half(input logic lr, input logic [23:0] w);
    for (int j = 0; j < t_hb; j++) begin
      if (t_mode == 0)      slot(lr, (j == 0) ? carry : dbit(w, j-1));
      else if (t_mode == 1) slot(lr, dbit(w, j));
      else                  slot(lr, (j >= t_hb - t_w) ? w[23-(j-(t_hb-t_w))] : 1'b1);
    end
    if (t_mode == 0) carry = dbit(w, t_hb-1);
  endtask

  function automatic logic [23:0] expv(input logic [23:0] w);
    return w & (24'hFFFFFF << (24 - t_w));
  endfunction

  task automatic cfg(input logic [2:0] f);
    pdn = 1'b1; fmt = f;
    wait_clk(4);
    case (f)
      3'b000: begin t_mode = 0; t_w = 24; t_hb = 32; end
      3'b001, 3'b111: begin t_mode = 0; t_w = 16; t_hb = 16; end
      3'b010: begin t_mode = 1; t_w = 24; t_hb = 32; end
      3'b011: begin t_mode = 2; t_w = 24; t_hb = 32; end
      3'b100: begin t_mode = 2; t_w = 20; t_hb = 32; end
      3'b101: begin t_mode = 2; t_w = 16; t_hb = 32; end
      default: begin t_mode = 2; t_w = 18; t_hb = 32; end
    endcase
    carry = 1'b1;
    pdn = 1'b0;
    wait_clk(4);
  endtask

  task automatic stream(input logic [23:0] l0, r0, l1, r1);
    logic lv;
    lv = (t_mode == 0) ? 1'b0 : 1'b1;
    send_half(~lv, 24'h0);
    send_half(lv, l0);
    send_half(~lv, r0);
    send_half(lv, l1);
    send_half(~lv, r1);
    send_half(lv, 24'h0);
    wait_clk(20);
  endtask

  task automatic run_fmt(input logic [2:0] f, input string req,
                         input logic [23:0] l0, r0, l1, r1);
    int base;
    cfg(f);
    base = n_valid;
    stream(l0, r0, l1, r1);
    check({req, " strobe count"}, 24'(n_valid - base), 24'd2);
    check({req, " left0"},  got_l[base % 64],     expv(l0));
    check({req, " right0"}, got_r[base % 64],     expv(r0));
    check({req, " left1"},  got_l[(base+1) % 64], expv(l1));
    check({req, " right1"}, got_r[(base+1) % 64], expv(r1));
  endtask

  task automatic test_reset;
    check("R9 left",  left_o,  24'h0);
    check("R9 right", right_o, 24'h0);
    check("R9 valid", {23'h0, valid_o}, 24'h0);
  endtask

  task automatic test_fmt_hold;
    int base;
    cfg(3'b010);
    fmt = 3'b000;   // R8: change while running must be ignored
    wait_clk(4);
    base = n_valid;
    stream(24'h13579B, 24'hFDB975, 24'h2468AC, 24'h0F0F0F);
    check("R8 strobe count", 24'(n_valid - base), 24'd2);
    check("R8 left0",  got_l[base % 64],     24'h13579B);
    check("R8 right1", got_r[(base+1) % 64], 24'h0F0F0F);
  endtask

  task automatic test_pdn;
    int base;
    check("R7 precondition nonzero", {23'h0, (left_o != 24'h0)}, 24'h1);
    pdn = 1'b1;
    wait_clk(2);
    check("R7 left cleared",  left_o,  24'h0);
    check("R7 right cleared", right_o, 24'h0);
    base = n_valid;
    carry = 1'b1;
    send_half(1'b1, 24'h0);
    send_half(1'b0, 24'hAAAAAA);
    send_half(1'b1, 24'h555555);
    send_half(1'b0, 24'h0);
    wait_clk(20);
    check("R7 no strobe", 24'(n_valid - base), 24'd0);
    check("R7 left quiet", left_o, 24'h0);
  endtask

  initial begin
    wait_clk(3);
    test_reset();
    rst_ni = 1'b1;
    wait_clk(3);
    test_reset();
    run_fmt(3'b000, "R1 R10", 24'hA5C3E1, 24'h5A3C1E, 24'h800001, 24'h7FFFFE);
    run_fmt(3'b001, "R2", 24'hBEEF12, 24'h1234FF, 24'h8001AA, 24'h7FFE55);
    run_fmt(3'b111, "R5", 24'hCAFE00, 24'h0BAD00, 24'h000100, 24'hFFFF00);
    run_fmt(3'b010, "R3", 24'hC0FFEE, 24'h123456, 24'h800000, 24'h000001);
    run_fmt(3'b011, "R4 w24", 24'h654321, 24'hFEDCBA, 24'h000001, 24'h800000);
    run_fmt(3'b100, "R4 w20", 24'hABCDEF, 24'h12345F, 24'h000010, 24'h80000F);
    run_fmt(3'b101, "R4 w16", 24'h4321FF, 24'hA5A5FF, 24'h000100, 24'h8000FF);
    run_fmt(3'b110, "R4 w18", 24'h35B7FF, 24'hCA48FF, 24'h000040, 24'h80003F);
    test_fmt_hold();
    test_pdn();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule